// File: doc/BRIEF.md
# Three-Button Mouse Packet Encoder

This block turns one pointer event into a five-byte packet and queues the bytes for a host that reads them one at a time. An event has a signed horizontal motion, a signed vertical motion and three button levels. The packet begins with a header byte of 0x87. Each pressed button clears its own bit in that header. The header is followed by the clamped horizontal motion, then the clamped and sign-flipped vertical motion, and then two zero bytes.

The packet bytes go into a byte queue of configurable depth, 256 by default. The host pops bytes from that queue. A level flag shows that the queue holds data. A one-cycle strobe marks each moment when the receive side should signal a fresh character to the host. A synchronous clear input discards everything queued.

Top module: `mouse_pkt_encoder`

## Requirements
- R1: The first byte of a packet is 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared for the middle button and bit 0 cleared for the right button.
- R2: The second byte is the horizontal motion clamped to the range -127..+127, in 8-bit two's complement (0x7F for large positive values, 0x81 for large negative values).
- R3: The third byte is the vertical motion negated and then clamped to -127..+127, in 8-bit two's complement. The negation must not overflow for the most negative input.
- R4: The fourth and fifth bytes are always 0x00.
- R5: An event is taken only while `enc_busy` is low. `enc_busy` rises on the edge that takes the event and stays high for exactly five cycles. During those cycles one packet byte is pushed per clock, in packet order. `evt_valid` while busy has no effect.
- R6: The queue holds up to FIFO_DEPTH bytes (256 by default). A push into a full queue is dropped, and the stored bytes and their order stay unchanged.
- R7: A pop returns the oldest byte on `rd_data` from the edge that takes the pop. A pop from an empty queue returns 0x00.
- R8: `rx_avail` is high exactly when the queue holds at least one byte, as of the last clock edge.
- R9: `rx_strobe` is high for one cycle after each edge that stores a pushed byte, or that pops a byte while at least one other byte remains.
- R10: A clear empties the queue on that edge. It overrides any push or pop in the same cycle, and the byte pushed in that cycle is lost.
- R11: After reset, `enc_busy`, `rx_avail` and `rx_strobe` are low and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous queue clear |
| evt_valid | input | 1 | Pointer event present |
| evt_dx | input | MOTION_W | Horizontal motion, two's complement |
| evt_dy | input | MOTION_W | Vertical motion, two's complement |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| enc_busy | output | 1 | Packet being written into the queue |
| rd_pop | input | 1 | Host pops one byte |
| rd_data | output | 8 | Byte returned by the last pop |
| rx_avail | output | 1 | Queue holds data |
| rx_strobe | output | 1 | Character-available pulse |

## Verification
If the queue pointers or occupancy count go wrong, a later pop shows it. `rd_data` returns a byte out of order or a stale byte, or `rx_avail` disagrees with the number of bytes pushed minus those popped. The reference model compares both outputs on every clock, so the error is seen within one cycle of the first affected pop. If the packet sequencer goes wrong, the result shows in `enc_busy` on the very next edge, and in the popped bytes as soon as they are read. The full-queue and clear cases are driven on purpose, because a wrong count there first shows up several hundred cycles later as a bad 256th byte or a missing zero return.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PKT_LEN = 5;
  localparam logic [BYTE_W-1:0] HDR_BASE = 8'h87;

  typedef struct packed {
    logic left;
    logic mid;
    logic right;
  } btn_t;

  function automatic logic [BYTE_W-1:0] header_byte(input btn_t b);
    header_byte = HDR_BASE & ~{5'b00000, b.left, b.mid, b.right};
  endfunction
endpackage

// File: rtl/mpe_pkt_build.sv
module mpe_pkt_build
  import mpe_pkg::*;
#(
  parameter int unsigned MOTION_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                evt_valid,
  input  logic [MOTION_W-1:0] evt_dx,
  input  logic [MOTION_W-1:0] evt_dy,
  input  btn_t                btns,
  output logic                busy,
  output logic                push_valid,
  output logic [BYTE_W-1:0]   push_data
);
  localparam int unsigned LW = $clog2(PKT_LEN + 1);
  localparam logic signed [MOTION_W:0] POS_LIM = (MOTION_W+1)'(127);
  localparam logic signed [MOTION_W:0] NEG_LIM = -POS_LIM;

  function automatic logic [BYTE_W-1:0] clamp8(input logic signed [MOTION_W:0] v);
    if (v > POS_LIM)      clamp8 = 8'h7F;
    else if (v < NEG_LIM) clamp8 = 8'h81;
    else                  clamp8 = v[BYTE_W-1:0];
  endfunction

  logic signed [MOTION_W:0] dx_ext, dy_neg;
  logic [BYTE_W-1:0] pkt_q [PKT_LEN];
  logic [LW-1:0]     left_q;
  logic              busy_q;

  always_comb begin
    dx_ext = $signed({evt_dx[MOTION_W-1], evt_dx});
    dy_neg = -$signed({evt_dy[MOTION_W-1], evt_dy});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      left_q <= '0;
      for (int i = 0; i < PKT_LEN; i++) pkt_q[i] <= '0;
    end else if (busy_q) begin
      for (int i = 0; i < PKT_LEN - 1; i++) pkt_q[i] <= pkt_q[i+1];
      pkt_q[PKT_LEN-1] <= '0;
      left_q <= left_q - LW'(1);
      if (left_q == LW'(1)) busy_q <= 1'b0;
    end else if (evt_valid) begin
      pkt_q[0] <= header_byte(btns);
      pkt_q[1] <= clamp8(dx_ext);
      pkt_q[2] <= clamp8(dy_neg);
      for (int i = 3; i < PKT_LEN; i++) pkt_q[i] <= '0;
      left_q <= LW'(PKT_LEN);
      busy_q <= 1'b1;
    end
  end

  assign busy       = busy_q;
  assign push_valid = busy_q;
  assign push_data  = pkt_q[0];

  assert_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !busy_q) |=> (busy_q && left_q == LW'(PKT_LEN)));
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && left_q == LW'(1)) |=> !busy_q);
  assert_tail_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && left_q <= LW'(2)) |-> (push_data == '0));
endmodule

// File: rtl/mpe_byte_fifo.sv
module mpe_byte_fifo #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          not_empty,
  output logic          strobe
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q, count_d;
  logic [DW-1:0] rd_q;
  logic avail_q, strobe_q;
  logic full, has_data, acc_wr, acc_rd;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full     = (count_q == CW'(DEPTH));
    has_data = (count_q != '0);
    acc_wr   = wr_en && !full && !clr;
    acc_rd   = rd_en && has_data && !clr;
    if (clr) count_d = '0;
    else     count_d = count_q + CW'(acc_wr) - CW'(acc_rd);
  end

  always_ff @(posedge clk) begin
    if (acc_wr) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_en && !clr) rd_q <= has_data ? mem[rptr_q] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      count_q  <= '0;
      avail_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      if (clr) begin
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        if (acc_wr) wptr_q <= nxt(wptr_q);
        if (acc_rd) rptr_q <= nxt(rptr_q);
      end
      count_q  <= count_d;
      avail_q  <= (count_d != '0);
      strobe_q <= !clr && (acc_wr || (acc_rd && count_q > CW'(1)));
    end
  end

  assign rd_data   = rd_q;
  assign not_empty = avail_q;
  assign strobe    = strobe_q;

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en && !clr) |=> (count_q == CW'(DEPTH)));
  assert_empty_pop_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !clr && !has_data && !wr_en) |=> (rd_data == '0 && !not_empty));
  assert_avail_match_R8: assert property (@(posedge clk) disable iff (rst)
    not_empty == (count_q != '0));
endmodule

// File: rtl/mouse_pkt_encoder.sv
module mouse_pkt_encoder
  import mpe_pkg::*;
#(
  parameter int unsigned MOTION_W   = 16,
  parameter int unsigned FIFO_DEPTH = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                evt_valid,
  input  logic [MOTION_W-1:0] evt_dx,
  input  logic [MOTION_W-1:0] evt_dy,
  input  logic                btn_left,
  input  logic                btn_mid,
  input  logic                btn_right,
  output logic                enc_busy,
  input  logic                rd_pop,
  output logic [7:0]          rd_data,
  output logic                rx_avail,
  output logic                rx_strobe
);
  btn_t              btns;
  logic              push_valid;
  logic [BYTE_W-1:0] push_data;

  assign btns = '{left: btn_left, mid: btn_mid, right: btn_right};

  mpe_pkt_build #(.MOTION_W(MOTION_W)) u_build (
    .clk        (clk),
    .rst        (rst),
    .evt_valid  (evt_valid),
    .evt_dx     (evt_dx),
    .evt_dy     (evt_dy),
    .btns       (btns),
    .busy       (enc_busy),
    .push_valid (push_valid),
    .push_data  (push_data)
  );

  mpe_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .wr_en     (push_valid),
    .wr_data   (push_data),
    .rd_en     (rd_pop),
    .rd_data   (rd_data),
    .not_empty (rx_avail),
    .strobe    (rx_strobe)
  );

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!rx_avail && !rx_strobe));
endmodule

// File: tb/mouse_pkt_encoder_bench.sv
module mouse_pkt_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;
  localparam int DEPTH      = 256;

  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, evt_valid = 1'b0, rd_pop = 1'b0;
  logic [15:0] evt_dx = '0, evt_dy = '0;
  logic btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
  logic enc_busy, rx_avail, rx_strobe;
  logic [7:0] rd_data;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] m_q[$];
  logic [7:0] m_pend[$];
  logic [7:0] m_rd = 8'h00;
  bit m_busy = 0, m_avail = 0, m_strobe = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mouse_pkt_encoder u_mouse_pkt_encoder (
    .clk(clk), .rst(rst), .clr(clr), .evt_valid(evt_valid),
    .evt_dx(evt_dx), .evt_dy(evt_dy), .btn_left(btn_left),
    .btn_mid(btn_mid), .btn_right(btn_right), .enc_busy(enc_busy),
    .rd_pop(rd_pop), .rd_data(rd_data), .rx_avail(rx_avail),
    .rx_strobe(rx_strobe)
  );

  function automatic int clamp(int v);
    if (v > 127) return 127;
    if (v < -127) return -127;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: advance the model using the current inputs, then compare
  task automatic tick();
    if (rst) begin
      m_q.delete(); m_pend.delete();
      m_rd = 0; m_busy = 0; m_avail = 0; m_strobe = 0;
    end else begin
      bit push_v, acc_push;
      logic [7:0] pb;
      int cnt;
      push_v = m_busy;
      pb = push_v ? m_pend[0] : 8'h00;
      cnt = m_q.size();
      if (clr) begin
        m_q.delete();
        m_strobe = 0;
      end else begin
        acc_push = push_v && (cnt < DEPTH);
        m_strobe = acc_push || (rd_pop && cnt >= 2);
        if (rd_pop) m_rd = (cnt > 0) ? m_q.pop_front() : 8'h00;
        if (acc_push) m_q.push_back(pb);
      end
      if (m_busy) begin
        void'(m_pend.pop_front());
        m_busy = (m_pend.size() != 0);
      end else if (evt_valid) begin
        m_pend.push_back(8'h87 & ~{5'b0, btn_left, btn_mid, btn_right});
        m_pend.push_back(8'(clamp(int'($signed(evt_dx)))));
        m_pend.push_back(8'(clamp(-int'($signed(evt_dy)))));
        m_pend.push_back(8'h00);
        m_pend.push_back(8'h00);
        m_busy = 1;
      end
      m_avail = (m_q.size() != 0);
    end
    @(posedge clk); #1;
    check("R5 enc_busy", enc_busy, m_busy);
    check("R8 rx_avail", rx_avail, m_avail);
    check("R9 rx_strobe", rx_strobe, m_strobe);
    check("R7 rd_data", rd_data, m_rd);
  endtask

  task automatic send(int dx, int dy, bit l, bit m, bit r);
    evt_dx = 16'(dx); evt_dy = 16'(dy);
    btn_left = l; btn_mid = m; btn_right = r;
    evt_valid = 1; tick(); evt_valid = 0;
  endtask

  task automatic pop_chk(string tag, int exp);
    rd_pop = 1; tick(); rd_pop = 0;
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    check("R11 busy after reset", enc_busy, 0);
    check("R11 avail after reset", rx_avail, 0);
    check("R11 strobe after reset", rx_strobe, 0);
    check("R11 rd_data after reset", rd_data, 0);
    tick();

    // basic packet: left button, dx=5, dy=3
    send(5, 3, 1, 0, 0);
    check("R5 busy after accept", enc_busy, 1);
    repeat (5) tick();
    check("R5 busy ends after five pushes", enc_busy, 0);
    pop_chk("R1 header left", 8'h83);
    check("R9 strobe on pop with data left", rx_strobe, 1);
    pop_chk("R2 dx small", 8'h05);
    pop_chk("R3 negated dy", 8'hFD);
    pop_chk("R4 byte four", 8'h00);
    pop_chk("R4 byte five", 8'h00);
    check("R8 avail after draining", rx_avail, 0);
    pop_chk("R7 pop empty gives zero", 8'h00);

    // saturation, all buttons; a second event while busy is ignored
    send(300, -500, 1, 1, 1);
    send(1, 1, 0, 0, 0);
    repeat (5) tick();
    pop_chk("R1 header all buttons", 8'h80);
    pop_chk("R2 dx clamp positive", 8'h7F);
    pop_chk("R3 -dy clamp positive", 8'h7F);
    repeat (2) begin rd_pop = 1; tick(); rd_pop = 0; end
    check("R5 event while busy ignored", rx_avail, 0);

    // extremes of the input range, middle and right buttons
    send(-32768, 32767, 0, 1, 0);
    repeat (5) tick();
    send(0, -32768, 0, 0, 1);
    repeat (5) tick();
    pop_chk("R1 header middle", 8'h85);
    pop_chk("R2 dx clamp negative", 8'h81);
    pop_chk("R3 -dy clamp negative", 8'h81);
    repeat (2) begin rd_pop = 1; tick(); rd_pop = 0; end
    pop_chk("R1 header right", 8'h86);
    pop_chk("R2 dx zero", 8'h00);
    pop_chk("R3 -dy no overflow", 8'h7F);
    repeat (2) begin rd_pop = 1; tick(); rd_pop = 0; end

    // fill past capacity: 51 packets plus one header byte fit
    for (int i = 0; i < 51; i++) begin
      send(i, 0, 0, 0, 0);
      repeat (5) tick();
    end
    send(7, 7, 1, 0, 0);
    repeat (5) tick();
    check("R6 avail when full", rx_avail, 1);
    for (int i = 0; i < DEPTH - 1; i++) begin rd_pop = 1; tick(); rd_pop = 0; end
    pop_chk("R6 last stored byte is header", 8'h83);
    check("R6 excess pushes dropped", rx_avail, 0);
    pop_chk("R7 pop past end gives zero", 8'h00);

    // clear in the middle of a packet
    send(9, 9, 0, 0, 0);
    tick(); tick();
    clr = 1; tick(); clr = 0;
    check("R10 clear empties queue", rx_avail, 0);
    repeat (2) tick();
    pop_chk("R10 byte after clear", 8'h00);
    pop_chk("R10 second byte after clear", 8'h00);
    check("R10 only post-clear bytes kept", rx_avail, 0);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      evt_dx = 16'($urandom_range(0, 65535));
      evt_dy = 16'($urandom_range(0, 65535));
      {btn_left, btn_mid, btn_right} = 3'($urandom_range(0, 7));
      evt_valid = ($urandom_range(0, 3) == 0);
      rd_pop = ($urandom_range(0, 2) == 0);
      clr = ($urandom_range(0, 99) == 0);
      tick();
    end
    evt_valid = 0; rd_pop = 0; clr = 0;
    repeat (6) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule